// File: doc/BRIEF.md
# Hardware Thread Issue Selector

This block decides, on every clock cycle, which of several hardware thread contexts may issue an instruction. A one-bit policy input chooses between two behaviours. In interleaved mode the issue slot rotates across the threads every cycle, and any thread whose ready bit is low is passed over. In sticky mode a single owning thread keeps the slot. Ownership moves only when the owner reports a long-latency stall, such as a miss in the second-level cache. Ordinary short stalls in sticky mode leave the slot empty.

Every thread keeps its own program counter inside the block, so a change of thread needs no save or restore of context. A program counter moves forward by one instruction word only in a cycle in which its thread issues. All outputs are registered. The decision made from the inputs at one clock edge appears on the outputs directly after that edge. The fetch logic downstream uses the thread number, the issue flag and the program counter of the issuing thread. The switch pulse tells it that the context has changed.

Top module: `thread_select_unit`

## Requirements
- R1: While reset is high and after it is released, issue_valid and switch_pulse are 0. The program counter of thread t is PC_BASE + t*PC_STRIDE. The rotation pointer holds thread NUM_THREADS-1, so the first interleaved search starts at thread 0, and the owner in sticky mode is thread NUM_THREADS-1.
- R2: In interleaved mode (policy_coarse=0), the issuing thread is the first thread with its ready bit set, searching upward from the pointer plus one and wrapping modulo NUM_THREADS. The pointer itself is checked last. The pointer then takes that thread's number. long_stall has no effect in this mode. Outputs reflect the inputs sampled at the previous rising edge.
- R3: In interleaved mode, a thread whose ready bit is 0 is skipped, and the next ready thread in rotation issues in that same cycle.
- R4: When no thread is eligible, issue_valid is 0, the pointer keeps its value and no program counter changes.
- R5: In sticky mode (policy_coarse=1), while the owner is ready and its long_stall bit is 0, the owner issues every cycle and switch_pulse stays 0.
- R6: In sticky mode, when the owner's ready bit is 0 and its long_stall bit is 0, issue_valid is 0, no switch happens and the owner is kept. The short stall is not hidden.
- R7: In sticky mode, when the owner's long_stall bit is 1, the new owner is the first thread other than the owner that has ready=1 and long_stall=0, searching upward from the owner plus one with wrap. That thread issues in the same cycle.
- R8: In sticky mode, a long stall on the owner with no eligible other thread gives issue_valid=0 and keeps the owner. A long_stall bit on a thread that is not the owner has no effect.
- R9: When a thread issues, issue_pc carries that thread's program counter before the increment. That counter then grows by 4. Every other thread's counter is unchanged.
- R10: switch_pulse is 1 for exactly the output cycles in which the issuing thread differs from the pointer value before that decision, in either mode. This makes it a one-cycle pulse per change of thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| policy_coarse | input | 1 | 0 = interleaved per cycle, 1 = sticky until long stall |
| thread_ready | input | NUM_THREADS | Per-thread ready to issue |
| long_stall | input | NUM_THREADS | Per-thread long-latency stall flag |
| issue_valid | output | 1 | A thread issues this cycle |
| issue_tid | output | $clog2(NUM_THREADS) | Issuing thread number |
| switch_pulse | output | 1 | Issuing thread differs from the previous pointer |
| issue_pc | output | PC_W | Program counter of the issuing thread |
| pc_all | output | NUM_THREADS*PC_W | All thread program counters, thread t at bits t*PC_W upward |

## Verification
The bench first walks every combination of ready and long-stall masks under both policies, so each pointer position meets full, partial and empty ready sets. This separates a correct wrap-around search from one that restarts at thread 0 or starts at the pointer itself. Sticky-mode passes tell a long stall on the owner apart from a long stall on some other thread, and a short stall apart from a long one. A long pseudo-random run with occasional policy changes then checks the program counters over many issues. It shows whether an increment lands on the wrong thread or a counter moves in a cycle with no issue.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
  typedef enum logic {
    POL_INTERLEAVE = 1'b0,
    POL_STICKY     = 1'b1
  } policy_e;

  localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/rr_picker.sv
module rr_picker #(
  parameter int N  = 4,
  parameter int TW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [TW-1:0] base,
  output logic          found,
  output logic [TW-1:0] idx
);
  // Walk offsets from farthest to nearest so the nearest request wins.
  always_comb begin
    int s;
    found = 1'b0;
    idx   = base;
    for (int k = N; k >= 1; k--) begin
      s = int'(base) + k;
      if (s >= N) s = s - N;
      if (req[s]) begin
        found = 1'b1;
        idx   = TW'(s);
      end
    end
  end
endmodule

// File: rtl/pc_bank.sv
module pc_bank #(
  parameter int          N         = 4,
  parameter int          PC_W      = 32,
  parameter int          TW        = 2,
  parameter logic [31:0] PC_BASE   = 32'h0,
  parameter logic [31:0] PC_STRIDE = 32'h100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic [TW-1:0]   adv_tid,
  output logic [PC_W-1:0] sel_pc,
  output logic [N*PC_W-1:0] pc_flat
);
  import tsu_pkg::*;

  logic [PC_W-1:0] pc_q [N];

  for (genvar t = 0; t < N; t++) begin : g_ctx
    localparam logic [PC_W-1:0] START = PC_W'(PC_BASE + PC_STRIDE * t);
    always_ff @(posedge clk) begin
      if (rst)
        pc_q[t] <= START;
      else if (adv && (adv_tid == TW'(t)))
        pc_q[t] <= pc_q[t] + PC_W'(INSN_BYTES);
    end
    assign pc_flat[t*PC_W +: PC_W] = pc_q[t];
  end

  always_comb begin
    sel_pc = pc_q[0];
    for (int t = 1; t < N; t++)
      if (adv_tid == TW'(t)) sel_pc = pc_q[t];
  end
endmodule

// File: rtl/thread_select_unit.sv
module thread_select_unit #(
  parameter int          NUM_THREADS = 4,
  parameter int          PC_W        = 32,
  parameter logic [31:0] PC_BASE     = 32'h0,
  parameter logic [31:0] PC_STRIDE   = 32'h100,
  localparam int         TW          = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      policy_coarse,
  input  logic [NUM_THREADS-1:0]    thread_ready,
  input  logic [NUM_THREADS-1:0]    long_stall,
  output logic                      issue_valid,
  output logic [TW-1:0]             issue_tid,
  output logic                      switch_pulse,
  output logic [PC_W-1:0]           issue_pc,
  output logic [NUM_THREADS*PC_W-1:0] pc_all
);
  import tsu_pkg::*;

  localparam logic [TW-1:0] PTR_RST = TW'(NUM_THREADS - 1);

  policy_e                pol;
  logic [TW-1:0]          ptr_q;
  logic [NUM_THREADS-1:0] owner_mask;
  logic [NUM_THREADS-1:0] cand;
  logic                   pk_found;
  logic [TW-1:0]          pk_idx;
  logic                   go;
  logic [TW-1:0]          go_tid;
  logic                   chg;
  logic [PC_W-1:0]        cur_pc;

  assign pol        = policy_e'(policy_coarse);
  assign owner_mask = NUM_THREADS'(1) << ptr_q;

  // Candidate set depends on the policy; one picker serves both.
  always_comb begin
    if (pol == POL_STICKY) cand = thread_ready & ~long_stall & ~owner_mask;
    else                   cand = thread_ready;
  end

  rr_picker #(.N(NUM_THREADS), .TW(TW)) u_pick (
    .req   (cand),
    .base  (ptr_q),
    .found (pk_found),
    .idx   (pk_idx)
  );

  always_comb begin
    go     = 1'b0;
    go_tid = ptr_q;
    unique case (pol)
      POL_INTERLEAVE: begin
        go     = pk_found;
        go_tid = pk_idx;
      end
      POL_STICKY: begin
        if (long_stall[ptr_q]) begin
          go     = pk_found;
          go_tid = pk_idx;
        end else begin
          go     = thread_ready[ptr_q];
          go_tid = ptr_q;
        end
      end
      default: ;
    endcase
    chg = go && (go_tid != ptr_q);
  end

  pc_bank #(
    .N(NUM_THREADS), .PC_W(PC_W), .TW(TW),
    .PC_BASE(PC_BASE), .PC_STRIDE(PC_STRIDE)
  ) u_pcs (
    .clk     (clk),
    .rst     (rst),
    .adv     (go),
    .adv_tid (go_tid),
    .sel_pc  (cur_pc),
    .pc_flat (pc_all)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q        <= PTR_RST;
      issue_valid  <= 1'b0;
      issue_tid    <= '0;
      switch_pulse <= 1'b0;
      issue_pc     <= '0;
    end else begin
      issue_valid  <= go;
      switch_pulse <= chg;
      if (go) begin
        ptr_q     <= go_tid;
        issue_tid <= go_tid;
        issue_pc  <= cur_pc;
      end
    end
  end
endmodule

// File: rtl/tsu_checker.sv
module tsu_checker #(
  parameter int N    = 4,
  parameter int PC_W = 32,
  parameter int TW   = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          policy_coarse,
  input logic [N-1:0]  thread_ready,
  input logic [N-1:0]  long_stall,
  input logic          issue_valid,
  input logic [TW-1:0] issue_tid,
  input logic          switch_pulse
);
  // R2: an issuing thread had its ready bit set at the deciding edge
  assert_issue_ready_R2: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> ((($past(thread_ready) >> issue_tid) & N'(1)) != '0));

  // R4: nothing ready means nothing issues
  assert_idle_when_none_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(thread_ready) == '0) |-> !issue_valid);

  // R6: sticky mode with no long stall anywhere never switches
  assert_no_switch_short_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(policy_coarse) && ($past(long_stall) == '0)) |-> !switch_pulse);

  // R10: a switch always comes with an issue
  assert_switch_issues_R10: assert property (@(posedge clk) disable iff (rst)
    switch_pulse |-> issue_valid);

  // R10: back-to-back issues without a switch keep the thread
  assert_same_thread_R10: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && $past(issue_valid) && !switch_pulse) |-> (issue_tid == $past(issue_tid)));

  // R10: a switch after an issue names a different thread
  assert_switch_differs_R10: assert property (@(posedge clk) disable iff (rst)
    (switch_pulse && $past(issue_valid)) |-> (issue_tid != $past(issue_tid)));
endmodule

bind thread_select_unit tsu_checker #(.N(NUM_THREADS), .PC_W(PC_W), .TW(TW)) u_tsu_chk (
  .clk           (clk),
  .rst           (rst),
  .policy_coarse (policy_coarse),
  .thread_ready  (thread_ready),
  .long_stall    (long_stall),
  .issue_valid   (issue_valid),
  .issue_tid     (issue_tid),
  .switch_pulse  (switch_pulse)
);

// File: tb/test_thread_select_unit.sv
module test_thread_select_unit;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int N    = 4;
  localparam int PC_W = 32;
  localparam int TW   = 2;
  localparam logic [31:0] BASE   = 32'h1000;
  localparam logic [31:0] STRIDE = 32'h100;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            policy_coarse = 1'b0;
  logic [N-1:0]    thread_ready = '0;
  logic [N-1:0]    long_stall = '0;
  logic            issue_valid;
  logic [TW-1:0]   issue_tid;
  logic            switch_pulse;
  logic [PC_W-1:0] issue_pc;
  logic [N*PC_W-1:0] pc_all;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  int          mptr;
  logic [31:0] mpc [N];

  always #5 clk = ~clk;

  thread_select_unit #(
    .NUM_THREADS(N), .PC_W(PC_W), .PC_BASE(BASE), .PC_STRIDE(STRIDE)
  ) i_thread_select_unit (
    .clk(clk), .rst(rst), .policy_coarse(policy_coarse),
    .thread_ready(thread_ready), .long_stall(long_stall),
    .issue_valid(issue_valid), .issue_tid(issue_tid),
    .switch_pulse(switch_pulse), .issue_pc(issue_pc), .pc_all(pc_all)
  );

  task automatic chk(input string tag, input string what,
                     input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  task automatic check_pcs(input string tag);
    for (int t = 0; t < N; t++)
      chk(tag, $sformatf("pc[%0d]", t), pc_all[t*PC_W +: PC_W], mpc[t]);
  endtask

  // One cycle: drive after the falling edge, sample 1 ns after the rising edge.
  task automatic step(input logic pol, input logic [N-1:0] rdy, input logic [N-1:0] ls);
    logic [N-1:0] cm;
    bit    found, go;
    int    sel, tid, s;
    string tag;
    @(negedge clk);
    policy_coarse = pol;
    thread_ready  = rdy;
    long_stall    = ls;
    cm = pol ? (rdy & ~ls & ~(N'(1) << mptr)) : rdy;
    found = 0; sel = mptr;
    for (int k = 1; k <= N; k++) begin
      s = (mptr + k) % N;
      if (!found && cm[s]) begin found = 1; sel = s; end
    end
    if (!pol) begin
      go = found; tid = sel;
      if (rdy == '0)                 tag = "R4";
      else if (!rdy[(mptr + 1) % N]) tag = "R3";
      else                           tag = "R2";
    end else if (ls[mptr]) begin
      go = found; tid = sel;
      tag = found ? "R7" : "R8";
    end else begin
      go = rdy[mptr]; tid = mptr;
      tag = go ? ((ls != '0) ? "R8" : "R5") : "R6";
    end
    @(posedge clk);
    #1;
    chk(tag, "issue_valid", issue_valid, go);
    chk("R10", "switch_pulse", switch_pulse, go && (tid != mptr));
    if (go) begin
      chk(tag, "issue_tid", issue_tid, tid);
      chk("R9", "issue_pc", issue_pc, mpc[tid]);
      mpc[tid] = mpc[tid] + 32'd4;
      mptr = tid;
    end
    check_pcs(go ? "R9" : "R4");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    mptr = N - 1;
    for (int t = 0; t < N; t++) mpc[t] = BASE + STRIDE * t;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "issue_valid", issue_valid, 0);
    chk("R1", "switch_pulse", switch_pulse, 0);
    check_pcs("R1");
    @(negedge clk);
    rst = 1'b0;
    // R1: first interleaved search begins at thread 0
    step(1'b0, 4'b1111, 4'b0000);
    chk("R1", "first tid", issue_tid, 0);
    // R2: full rotation 1,2,3,0
    for (int i = 0; i < 4; i++) step(1'b0, 4'b1111, 4'b0000);
    // R3: skip stalled threads, R2: long_stall ignored in interleaved mode
    for (int i = 0; i < 6; i++) step(1'b0, 4'b1010, 4'b1111);
    // R4: empty cycles keep the pointer
    step(1'b0, 4'b0000, 4'b0000);
    step(1'b0, 4'b0000, 4'b0000);
    step(1'b0, 4'b1111, 4'b0000);
    // R5/R6/R7/R8 directed sticky sequence
    for (int i = 0; i < 3; i++) step(1'b1, 4'b1111, 4'b0000);
    step(1'b1, 4'b1111 & ~(4'b1 << mptr), 4'b0000);
    step(1'b1, 4'b1111, 4'b1111 & ~(4'b1 << mptr));
    step(1'b1, 4'b1111, 4'b1 << mptr);
    step(1'b1, 4'b1111, 4'b1111);
    step(1'b1, 4'b0000, 4'b1 << mptr);
    // Exhaustive sweep over both policies and all masks
    for (int p = 0; p < 2; p++)
      for (int rm = 0; rm < 16; rm++)
        for (int lm = 0; lm < 16; lm++)
          step(p[0], rm[3:0], lm[3:0]);
    // Pseudo-random run
    r = 32'h1ACE_B00C;
    for (int i = 0; i < 3000; i++) begin
      r ^= r << 13; r ^= r >> 17; r ^= r << 5;
      step(r[20] & r[21], r[3:0] | r[7:4], r[11:8] & r[15:12] & r[19:16]);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule